// File: doc/BRIEF.md
# Protected Control Register Serial Front-End

This block sits behind a two-wire serial slave and owns one 8-bit control register. The bit-level receiver in front of it reports bus events already decoded: a start condition, a stop condition and each received byte. The block returns an acknowledge decision for every byte and supplies the register contents when the master reads it. The register holds a two-bit watchdog select, a two-bit power-up select, a two-bit block-protect field and two volatile write-enable latches.

Changes to the six persistent bits are guarded. The master first sets the write-enable latch, then the register-write-enable latch, and only then sends the value. That is three separate write transactions. A stop condition after an accepted value copies it into the modelled nonvolatile store. This starts a timed busy interval, during which the device refuses every slave byte. A power-on reset clears the latches and leaves the stored bits as they were.

Top module: `ctl_reg_front`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ack_stb, rd_stb and busy are 0. Both latches read back as 0.
- R2: A slave byte is claimed only if bits 7:4 equal 1011b and bits 3:2 equal DEV_ID (default 00b). Bit 1 is word-address bit 8 and bit 0 is the direction (1 = read). Any other slave byte is not acknowledged and changes nothing.
- R3: Read data is ordered from bit 7 down to bit 0 as: power-up select high, watchdog select high, watchdog select low, block-protect high, block-protect low, register-write-enable latch, write-enable latch, power-up select low.
- R4: Data byte 02h, written at word address 1FFh while the register-write-enable latch is 0, sets the write-enable latch at the following stop.
- R5: Data byte 06h sets the register-write-enable latch at the following stop only if the write-enable latch was already 1. Otherwise it has no effect.
- R6: A data byte changes the persistent bits only if the register-write-enable latch is 1 when it arrives. Other data bytes leave the register unchanged.
- R7: Only the first data byte of a write is acknowledged. Later data bytes are not acknowledged and do not alter the pending value.
- R8: The stop after an accepted value stores the six persistent bits and clears both latches. Two cycles after the stop is sampled, busy rises, and it stays high for exactly BUSY_CYCLES cycles.
- R9: While busy is high, every slave byte is not acknowledged.
- R10: A write whose word address is not 1FFh has its data byte refused. A start or stop that arrives before the data byte abandons the write with no effect.
- R11: A slave read byte is acknowledged only if the last accepted word address was 1FFh. In that case rd_stb pulses together with the acknowledge, and rd_data carries the register.
- R12: A power-on reset clears both latches and the word-address pointer, and the persistent bits keep their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ev_start | input | 1 | Start or repeated start detected (one-cycle strobe) |
| ev_stop | input | 1 | Stop detected (one-cycle strobe) |
| byte_valid | input | 1 | A full byte has been received (one-cycle strobe) |
| byte_data | input | 8 | Received byte, valid with byte_valid |
| ack_stb | output | 1 | Acknowledge decision valid, one cycle after byte_valid |
| ack | output | 1 | 1 = acknowledge the byte, 0 = leave it unacknowledged |
| rd_stb | output | 1 | Register read data is being supplied |
| rd_data | output | 8 | Register contents for the read |
| busy | output | 1 | Nonvolatile store cycle in progress |

## Verification
The assertions assume that start, stop and byte strobes never coincide in one cycle. They also assume that bytes arrive in bus order, slave byte first, and that the only source of a commit is a stop after a latched value. The bench drives every strobe through tasks that raise exactly one input for one cycle. Outside one directed probe that deliberately addresses the device mid-cycle, it waits for busy to fall before starting a new transaction. The random transactions mix wrong preambles, wrong device bits, stray word addresses, extra data bytes and abandoned writes. Each transaction is compared against a bench model of the latches, pointer and stored bits.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam logic [3:0] REG_PREAMBLE  = 4'b1011;
    localparam logic [8:0] REG_WORD_ADDR = 9'h1FF;
    localparam logic [7:0] CMD_SET_WEL   = 8'h02;
    localparam logic [7:0] CMD_SET_RWEL  = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SLAVE = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_EXTRA = 3'd4,
        ST_SKIP  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WEL   = 2'd1,
        OP_RWEL  = 2'd2,
        OP_STORE = 2'd3
    } pend_op_e;

    typedef struct packed {
        logic pup1;
        logic wd1;
        logic wd0;
        logic bp1;
        logic bp0;
        logic pup0;
    } persist_t;

    function automatic logic [7:0] pack_reg(persist_t p, logic wel, logic rwel);
        return {p.pup1, p.wd1, p.wd0, p.bp1, p.bp0, rwel, wel, p.pup0};
    endfunction
endpackage

// File: rtl/ctl_nvstore.sv
module ctl_nvstore
    import ctl_pkg::*;
#(
    parameter int          BUSY_CYCLES = 40,
    parameter logic [5:0]  NV_INIT     = 6'h00
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit_i,
    input  persist_t commit_bits_i,
    output persist_t bits_o,
    output logic     busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    persist_t      bits_d;
    persist_t      bits_q = persist_t'(NV_INIT);

    always_comb begin
        cnt_d  = cnt_q;
        bits_d = bits_q;
        if (commit_i) begin
            cnt_d  = CW'(BUSY_CYCLES);
            bits_d = commit_bits_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // busy timer is volatile
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // stored bits survive a power-on reset
    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    assign bits_o = bits_q;
    assign busy_o = (cnt_q != '0);

    // R8
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> busy_o);

    // R12
    bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit_i) |-> $stable(bits_q));
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_pkg::*;
#(
    parameter logic [1:0] DEV_ID = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  persist_t   bits_i,
    input  logic       busy_i,
    output logic       commit_o,
    output persist_t   commit_bits_o,
    output logic       ack_stb_o,
    output logic       ack_o,
    output logic       rd_stb_o,
    output logic [7:0] rd_data_o
);
    typedef struct packed {
        seq_state_e state;
        pend_op_e   pend;
        persist_t   staged;
        logic       a8;
        logic       ptr_hit;
        logic       wel;
        logic       rwel;
        logic       ack_stb;
        logic       ack;
        logic       rd_stb;
        logic [7:0] rd_data;
        logic       commit;
    } seq_regs_t;

    seq_regs_t q, n;
    logic      claim;

    assign claim = (byte_data[7:4] == REG_PREAMBLE) && (byte_data[3:2] == DEV_ID) && !busy_i;

    always_comb begin
        n         = q;
        n.ack_stb = 1'b0;
        n.ack     = 1'b0;
        n.rd_stb  = 1'b0;
        n.commit  = 1'b0;
        if (ev_start) begin
            n.state = ST_SLAVE;
            n.pend  = OP_NONE;
        end else if (ev_stop) begin
            case (q.pend)
                OP_WEL:   n.wel  = 1'b1;
                OP_RWEL:  n.rwel = 1'b1;
                OP_STORE: begin
                    n.commit = 1'b1;
                    n.wel    = 1'b0;
                    n.rwel   = 1'b0;
                end
                default: ;
            endcase
            n.pend  = OP_NONE;
            n.state = ST_IDLE;
        end else if (byte_valid) begin
            n.ack_stb = 1'b1;
            case (q.state)
                ST_SLAVE: begin
                    n.state = ST_SKIP;
                    if (claim && !byte_data[0]) begin
                        n.ack   = 1'b1;
                        n.a8    = byte_data[1];
                        n.state = ST_ADDR;
                    end else if (claim) begin
                        n.ack     = q.ptr_hit;
                        n.rd_stb  = q.ptr_hit;
                        n.rd_data = pack_reg(bits_i, q.wel, q.rwel);
                    end
                end
                ST_ADDR: begin
                    n.ack     = 1'b1;
                    n.ptr_hit = ({q.a8, byte_data} == REG_WORD_ADDR);
                    n.state   = ST_DATA;
                end
                ST_DATA: begin
                    if (q.ptr_hit) begin
                        n.ack   = 1'b1;
                        n.state = ST_EXTRA;
                        if (q.rwel) begin
                            n.pend   = OP_STORE;
                            n.staged = '{pup1: byte_data[7], wd1: byte_data[6], wd0: byte_data[5],
                                         bp1: byte_data[4], bp0: byte_data[3], pup0: byte_data[0]};
                        end else if (byte_data == CMD_SET_WEL) begin
                            n.pend = OP_WEL;
                        end else if (byte_data == CMD_SET_RWEL && q.wel) begin
                            n.pend = OP_RWEL;
                        end
                    end else begin
                        n.state = ST_SKIP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.pend  <= OP_NONE;
        end else begin
            q <= n;
        end
    end

    assign commit_o      = q.commit;
    assign commit_bits_o = q.staged;
    assign ack_stb_o     = q.ack_stb;
    assign ack_o         = q.ack;
    assign rd_stb_o      = q.rd_stb;
    assign rd_data_o     = q.rd_data;

    // R5
    rwel_after_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rwel) |-> $past(q.wel));

    // R6
    store_needs_rwel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> $past(q.rwel));

    // R8
    latches_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> (!q.wel && !q.rwel));

    // R7
    extra_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ack_stb && $past(q.state) == ST_EXTRA) |-> !q.ack);

    // R9
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ack_stb && $past(busy_i) && $past(q.state) == ST_SLAVE) |-> !q.ack);

    // R11
    read_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd_stb |-> (q.ack && q.ack_stb));
endmodule

// File: rtl/ctl_reg_front.sv
module ctl_reg_front
    import ctl_pkg::*;
#(
    parameter logic [1:0] DEV_ID      = 2'b00,
    parameter int         BUSY_CYCLES = 40,
    parameter logic [5:0] NV_INIT     = 6'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       ack_stb,
    output logic       ack,
    output logic       rd_stb,
    output logic [7:0] rd_data,
    output logic       busy
);
    persist_t bits;
    persist_t commit_bits;
    logic     commit;

    ctl_seq #(.DEV_ID(DEV_ID)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_start     (ev_start),
        .ev_stop      (ev_stop),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .bits_i       (bits),
        .busy_i       (busy),
        .commit_o     (commit),
        .commit_bits_o(commit_bits),
        .ack_stb_o    (ack_stb),
        .ack_o        (ack),
        .rd_stb_o     (rd_stb),
        .rd_data_o    (rd_data)
    );

    ctl_nvstore #(.BUSY_CYCLES(BUSY_CYCLES), .NV_INIT(NV_INIT)) u_nv (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .commit_bits_i(commit_bits),
        .bits_o       (bits),
        .busy_o       (busy)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ack_stb && !rd_stb && !busy));
endmodule

// File: tb/sim_ctl_reg_front.sv
module sim_ctl_reg_front;
    localparam int         BUSY = 40;
    localparam logic [1:0] DEV  = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 1'b0, ev_stop = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic ack_stb, ack, rd_stb, busy;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [5:0] m_nv = 6'h00;
    logic m_wel = 1'b0, m_rwel = 1'b0, m_ptr = 1'b0;

    always #2 clk = ~clk;

    ctl_reg_front #(.DEV_ID(DEV), .BUSY_CYCLES(BUSY), .NV_INIT(6'h00)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .ack_stb(ack_stb), .ack(ack),
        .rd_stb(rd_stb), .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [7:0] exp_reg();
        return {m_nv[5], m_nv[4], m_nv[3], m_nv[2], m_nv[1], m_rwel, m_wel, m_nv[0]};
    endfunction

    function automatic bit slave_ok(logic [7:0] s);
        return (s[7:4] == 4'b1011) && (s[3:2] == DEV);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) ev_start = 1'b1;
        @(negedge clk) ev_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) ev_stop = 1'b1;
        @(negedge clk) ev_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
        @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
        @(negedge clk) byte_valid = 1'b0;
        chk(ack_stb == 1'b1, {tag, " ack_stb"}, ack_stb, 1);
        chk(ack == exp_ack, tag, ack, exp_ack);
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 10000) begin n++; @(negedge clk); end
    endtask

    // R8 busy length and commit; R9 probe during busy
    task automatic finish_store(input bit probe);
        int n = 0;
        chk(busy == 1'b0, "R8 busy before rise", busy, 0);
        @(negedge clk);
        if (probe) begin
            chk(busy == 1'b1, "R9 busy high", busy, 1);
            pulse_start();
            send(8'hB2, 1'b0, "R9 slave nack while busy");
            pulse_stop();
            wait_idle();
        end else begin
            while (busy && n < 10000) begin n++; @(negedge clk); end
            chk(n == BUSY, "R8 busy length", n, BUSY);
        end
    endtask

    task automatic write_txn(input logic [7:0] slv, input logic [7:0] adr, input logic [7:0] dat,
                             input int ndata, input bit abandon, input bit probe, input string tag);
        bit ok;
        int op = 0;
        logic [5:0] staged = '0;
        ok = slave_ok(slv);
        pulse_start();
        send(slv, ok, {tag, " R2 slave"});
        send(adr, ok, {tag, " R10 addr"});
        if (ok) m_ptr = slv[1] && (adr == 8'hFF);
        for (int i = 0; i < ndata; i++) begin
            bit first_ok;
            first_ok = (i == 0) && ok && m_ptr;
            send(dat ^ 8'(i), first_ok, i == 0 ? {tag, " R10 data"} : {tag, " R7 extra"});
            if (first_ok) begin
                if (m_rwel) begin op = 3; staged = {dat[7], dat[6], dat[5], dat[4], dat[3], dat[0]}; end
                else if (dat == 8'h02) op = 1;
                else if (dat == 8'h06 && m_wel) op = 2;
            end
        end
        if (abandon) begin
            pulse_start();
            op = 0;
        end
        pulse_stop();
        case (op)
            1: m_wel = 1'b1;
            2: m_rwel = 1'b1;
            3: begin m_nv = staged; m_wel = 1'b0; m_rwel = 1'b0; finish_store(probe); end
            default: @(negedge clk);
        endcase
    endtask

    task automatic read_txn(input bit setptr, input string tag);
        if (setptr) begin
            pulse_start();
            send(8'hB2, 1'b1, {tag, " R11 set slave"});
            send(8'hFF, 1'b1, {tag, " R11 set addr"});
            m_ptr = 1'b1;
        end
        pulse_start();
        @(negedge clk) begin byte_valid = 1'b1; byte_data = 8'hB3; end
        @(negedge clk) byte_valid = 1'b0;
        chk(ack == m_ptr, {tag, " R11 read ack"}, ack, m_ptr);
        chk(rd_stb == m_ptr, {tag, " R11 rd_stb"}, rd_stb, m_ptr);
        if (m_ptr) chk(rd_data == exp_reg(), {tag, " R3 read data"}, rd_data, exp_reg());
        pulse_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(ack_stb == 0 && rd_stb == 0 && busy == 0, "R1 during reset", {ack_stb, rd_stb, busy}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(ack_stb == 0 && rd_stb == 0 && busy == 0, "R1 after reset", {ack_stb, rd_stb, busy}, 0);
        // R11 pointer cleared by reset: read refused
        read_txn(1'b0, "R11 no pointer");
        read_txn(1'b1, "R1 latches zero");
        // R5 06h without WEL ignored
        write_txn(8'hB2, 8'hFF, 8'h06, 1, 0, 0, "R5 no wel");
        read_txn(1'b1, "R5 check");
        // R6 other data without RWEL ignored
        write_txn(8'hB2, 8'hFF, 8'hFF, 1, 0, 0, "R6 locked");
        read_txn(1'b1, "R6 check");
        // R4 and R5
        write_txn(8'hB2, 8'hFF, 8'h02, 1, 0, 0, "R4 set wel");
        read_txn(1'b1, "R4 check");
        write_txn(8'hB2, 8'hFF, 8'h06, 1, 0, 0, "R5 set rwel");
        read_txn(1'b1, "R5 check2");
        // R10 wrong address and abandon keep latches
        write_txn(8'hB0, 8'hFF, 8'hA5, 1, 0, 0, "R10 addr 0FF");
        write_txn(8'hB2, 8'hFF, 8'hA5, 0, 0, 0, "R10 stop early");
        write_txn(8'hB2, 8'hFF, 8'hA5, 1, 1, 0, "R10 restart");
        read_txn(1'b1, "R10 check");
        // R2 wrong preamble and device
        write_txn(8'hA2, 8'hFF, 8'hA5, 1, 0, 0, "R2 preamble");
        write_txn(8'hB6, 8'hFF, 8'hA5, 1, 0, 0, "R2 device");
        // R7 and R8: store with extra byte
        write_txn(8'hB2, 8'hFF, 8'hA5, 2, 0, 0, "R8 store");
        read_txn(1'b1, "R8 check");
        // R9 probe during busy
        write_txn(8'hB2, 8'hFF, 8'h02, 1, 0, 0, "R9 wel");
        write_txn(8'hB2, 8'hFF, 8'h06, 1, 0, 0, "R9 rwel");
        write_txn(8'hB2, 8'hFF, 8'h5A, 1, 0, 1, "R9 store");
        read_txn(1'b1, "R9 check");
        // R12 power cycle with latches set
        write_txn(8'hB2, 8'hFF, 8'h02, 1, 0, 0, "R12 wel");
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_wel = 1'b0; m_rwel = 1'b0; m_ptr = 1'b0;
        read_txn(1'b0, "R12 pointer cleared");
        read_txn(1'b1, "R12 persist kept");
        // random mix
        for (int t = 0; t < 120; t++) begin
            logic [7:0] slv, adr, dat;
            int r, nd;
            r = $urandom_range(0, 99);
            slv = (r < 80) ? 8'hB2 : (r < 87) ? 8'hA2 : (r < 94) ? 8'hB6 : 8'hB0;
            adr = ($urandom_range(0, 99) < 85) ? 8'hFF : 8'($urandom);
            r = $urandom_range(0, 99);
            dat = (r < 30) ? 8'h02 : (r < 60) ? 8'h06 : 8'($urandom);
            r = $urandom_range(0, 99);
            nd = (r < 10) ? 0 : (r < 85) ? 1 : 2;
            write_txn(slv, adr, dat, nd, $urandom_range(0, 9) == 0, 0, "rand R6");
            if ($urandom_range(0, 2) == 0) read_txn($urandom_range(0, 3) != 0, "rand R3");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule